// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Captured Seconds

This block keeps elapsed time as two counters: a sub-second millisecond count and a 32-bit seconds count. Both advance from a one-cycle tick-enable input that pulses at 1 kHz. Once reset is released, the counters never stop. The block has no suspend or enable control, so time keeps running while the rest of the system sleeps.

Software reaches the counters through a small register port. The port has three word registers:

| Register | Offset |
|---|---|
| live seconds | 0x08 |
| captured seconds | 0x0C |
| milliseconds | 0x10 |

A read of the milliseconds register copies the seconds count from that same cycle into the captured-seconds register. Software should read milliseconds first and captured seconds second. That order gives a pair that cannot tear across a seconds carry, and the full time in milliseconds is seconds × 1000 + milliseconds.

Top module: `ms_rtc`

## Requirements
- R1: A synchronous reset clears the millisecond count, the seconds count, the captured-seconds register and the read data to zero.
- R2: Each cycle with `tick` high raises the millisecond count by one. In a cycle with `tick` low, the millisecond count keeps its value.
- R3: The millisecond count stays within 0..999. A tick taken at 999 sets it to 0 and adds one to the seconds count in the same cycle.
- R4: The seconds count wraps modulo 2^32, so 0xFFFFFFFF is followed by 0.
- R5: A read of offset 0x10 loads the captured-seconds register with the seconds value after that cycle's carry or write. At any other time the captured-seconds register keeps its value.
- R6: Read data is registered. One cycle after a read, `reg_rdata` shows the post-update value of the addressed register: 0x08 gives seconds, 0x0C gives captured seconds and 0x10 gives milliseconds, zero-extended. Any other offset returns 0. `reg_rdata` holds its value in cycles without a read.
- R7: A write to offset 0x08 loads the seconds count with `reg_wdata`. The write takes precedence over a carry in the same cycle, and the millisecond count still advances on that cycle's tick.
- R8: Writes to offsets 0x0C and 0x10 change neither the captured-seconds register nor the millisecond count.
- R9: Reading 0x10 and then 0x0C gives a pair whose value, seconds × 1000 + milliseconds, equals the number of ticks counted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 kHz time-base enable, one cycle wide |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The embedded assertions check the following on every cycle:
- the millisecond count stays in range;
- the count holds without a tick, steps by one on a tick and carries at 999;
- the seconds register loads on a write;
- the captured-seconds register holds unless milliseconds is read, and matches the seconds count after a read.

The bench scenarios cover what cycle-local properties cannot show. These are:
- the end-to-end timestamp over thousands of ticks;
- the modulo-2^32 rollover of seconds;
- a read taken in the same cycle as a carry;
- ignored writes, seen through later reads;
- the value returned for unmapped offsets.

// File: rtl/ms_rtc.sv
module ms_rtc #(
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 5'h08,
  parameter logic [ADDR_W-1:0] SHD_ADDR = 5'h0C,
  parameter logic [ADDR_W-1:0] MS_ADDR  = 5'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int MS_W   = $clog2(MS_PER_SEC);
  localparam int MS_MAX = MS_PER_SEC - 1;

  logic [MS_W-1:0]   ms_q, ms_d;
  logic [DATA_W-1:0] sec_q, sec_d, shd_q, shd_d, rd_mux;

  wire wrap   = tick && (ms_q == MS_W'(MS_MAX));
  wire sec_wr = reg_wr && (reg_addr == SEC_ADDR);
  wire ms_rd  = reg_rd && (reg_addr == MS_ADDR);

  assign ms_d  = !tick ? ms_q : (wrap ? '0 : ms_q + MS_W'(1));
  assign sec_d = sec_wr ? reg_wdata : (wrap ? sec_q + DATA_W'(1) : sec_q);
  assign shd_d = ms_rd ? sec_d : shd_q;

  always_comb begin
    case (reg_addr)
      SEC_ADDR: rd_mux = sec_d;
      SHD_ADDR: rd_mux = shd_d;
      MS_ADDR:  rd_mux = DATA_W'(ms_d);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q      <= '0;
      sec_q     <= '0;
      shd_q     <= '0;
      reg_rdata <= '0;
    end else begin
      ms_q  <= ms_d;
      sec_q <= sec_d;
      shd_q <= shd_d;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R3: millisecond count never leaves its range
  p_ms_range_r3: assert property (@(posedge clk) disable iff (rst)
    int'(ms_q) <= MS_MAX);
  // R2: no tick, no change
  p_ms_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ms_q));
  // R2: tick below the top steps by one
  p_ms_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && int'(ms_q) != MS_MAX) |=> ms_q == $past(ms_q) + MS_W'(1));
  // R3: carry into seconds
  p_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && int'(ms_q) == MS_MAX && !sec_wr) |=>
      (ms_q == '0 && sec_q == $past(sec_q) + DATA_W'(1)));
  // R7: write loads seconds
  p_sec_load_r7: assert property (@(posedge clk) disable iff (rst)
    sec_wr |=> sec_q == $past(reg_wdata));
  // R5: captured seconds hold without a millisecond read
  p_shd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ms_rd |=> $stable(shd_q));
  // R5: capture matches the updated seconds count
  p_shd_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ms_rd |=> shd_q == sec_q);
  // R6: millisecond read returns the updated count
  p_ms_rdata_r6: assert property (@(posedge clk) disable iff (rst)
    ms_rd |=> reg_rdata == DATA_W'(ms_q));
  // R6: read data holds without a read
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/ms_rtc_tb.sv
module ms_rtc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint unsigned m_ms = 0, m_s = 0, m_shd = 0, total = 0;
  logic [31:0] got;

  always #2 clk = ~clk;

  ms_rtc u_dut (
    .clk(clk), .rst(rst), .tick(tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, return read data at next negedge
  task automatic cyc(input bit tk, input bit rd, input bit wr, input logic [4:0] a,
                     input logic [31:0] wd, output logic [31:0] rdv, output logic [31:0] expv);
    tick = tk; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    if (tk) begin
      total++;
      if (m_ms == 999) begin m_ms = 0; m_s = (m_s + 1) & 32'hFFFF_FFFF; end
      else m_ms++;
    end
    if (wr && a == 5'h08) m_s = wd;
    if (rd && a == 5'h10) m_shd = m_s;
    case (a)
      5'h08: expv = 32'(m_s);
      5'h0C: expv = 32'(m_shd);
      5'h10: expv = 32'(m_ms);
      default: expv = 32'h0;
    endcase
    @(negedge clk);
    tick = 0; reg_rd = 0; reg_wr = 0;
    rdv = reg_rdata;
  endtask

  task automatic ticks(input int n);
    logic [31:0] r, e;
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 5'h00, 0, r, e);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, e, r2, e2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    cyc(0, 1, 0, 5'h08, 0, r, e); chk("R1 secs", r, 0);
    cyc(0, 1, 0, 5'h0C, 0, r, e); chk("R1 shadow", r, 0);
    cyc(0, 1, 0, 5'h10, 0, r, e); chk("R1 ms", r, 0);

    // R2/R3/R5/R9 sweep across several seconds
    for (int i = 0; i < 2600; i++) begin
      cyc(1, 1, 0, 5'h10, 0, r, e); chk("R2 R3 ms sweep", r, e);
      if (i % 97 == 13) begin
        cyc(0, 1, 0, 5'h0C, 0, r2, e2); chk("R5 shadow sweep", r2, e2);
        chk("R9 timestamp", r2 * 1000 + r, 32'(total));
      end
    end
    // R2 hold without tick
    cyc(0, 1, 0, 5'h10, 0, r, e);
    repeat (5) cyc(0, 0, 0, 5'h00, 0, r2, e2);
    cyc(0, 1, 0, 5'h10, 0, r2, e2); chk("R2 hold", r2, r);
    // R6 rdata holds, unmapped reads 0
    cyc(0, 0, 0, 5'h08, 0, r, e); chk("R6 hold", r, r2);
    cyc(0, 1, 0, 5'h00, 0, r, e); chk("R6 unmapped", r, 0);
    cyc(0, 1, 0, 5'h1C, 0, r, e); chk("R6 unmapped", r, 0);

    // R5 read in the carry cycle
    while (m_ms != 998) ticks(1);
    cyc(1, 1, 0, 5'h10, 0, r, e); chk("R3 at 999", r, 999);
    cyc(1, 1, 0, 5'h10, 0, r, e); chk("R3 carry ms", r, 0);
    cyc(0, 1, 0, 5'h0C, 0, r, e); chk("R5 carry capture", r, e);
    cyc(0, 1, 0, 5'h08, 0, r2, e2); chk("R5 shadow equals secs", r, r2);

    // R8 ignored writes
    cyc(0, 1, 0, 5'h0C, 0, r, e);
    cyc(0, 0, 1, 5'h0C, 32'hAAAA_5555, r2, e2);
    cyc(0, 0, 1, 5'h10, 32'd500, r2, e2);
    cyc(0, 1, 0, 5'h0C, 0, r2, e2); chk("R8 shadow", r2, r);
    cyc(0, 1, 0, 5'h10, 0, r2, e2); chk("R8 ms", r2, 32'(m_ms));

    // R7 write loads seconds
    cyc(0, 1, 1, 5'h08, 32'hFFFF_FFFE, r, e); chk("R7 load", r, 32'hFFFF_FFFE);
    // R4 wrap modulo 2^32
    while (m_ms != 999) ticks(1);
    ticks(1);
    cyc(0, 1, 0, 5'h08, 0, r, e); chk("R4 before wrap", r, 32'hFFFF_FFFF);
    ticks(1000);
    cyc(0, 1, 0, 5'h10, 0, r, e); chk("R4 ms", r, 0);
    cyc(0, 1, 0, 5'h0C, 0, r, e); chk("R4 wrap", r, 0);

    // R7 write wins over carry, ms still advances
    while (m_ms != 999) ticks(1);
    cyc(1, 0, 1, 5'h08, 32'd100, r, e);
    cyc(0, 1, 0, 5'h08, 0, r, e); chk("R7 write over carry", r, 100);
    cyc(0, 1, 0, 5'h10, 0, r, e); chk("R7 ms advanced", r, 0);

    // R1 reset again mid-run
    rst = 1; @(negedge clk); rst = 0;
    m_ms = 0; m_s = 0; m_shd = 0;
    chk("R1 rdata after reset", reg_rdata, 0);
    cyc(0, 1, 0, 5'h08, 0, r, e); chk("R1 secs after reset", r, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule